// File: doc/BRIEF.md
# Multidrop Scan-Chain Linker

This block sits between one shared backplane test bus and four local test ports on a board. Many boards hang in parallel on the same backplane wires. Each linker runs its own test-access state machine clocked by the backplane TCK. A controller first shifts a select command into every linker's instruction register at once. Only the linker whose slot input matches the address in that command becomes selected and starts driving its backplane TDO. The controller then sends a link command, and the selected linker splices the chosen local ports in series between backplane TDI and TDO.

Once ports are linked, the linker itself drops out of the chain. Both instruction and data scans see only the linked devices. The selection holds until the state machine returns to Test-Logic-Reset, through five TCK cycles with TMS high or through TRST low. An on-board CPU can request the local ports while the board is deselected. Once granted, it drives all four ports as one chain. When neither the backplane nor the CPU owns a port, that port's output enable is low, so an external tester can drive it.

The state machine has sixteen states. TAP_RESET goes to TAP_IDLE on TMS low. TAP_IDLE goes to TAP_SEL_DR on TMS high. TAP_SEL_DR goes to TAP_SEL_IR on TMS high and to TAP_CAP_DR on TMS low. TAP_SEL_IR goes to TAP_RESET on TMS high and to TAP_CAP_IR on TMS low. Each of the two columns (DR and IR) has capture, shift, exit1, pause, exit2 and update states. From capture, TMS low goes to shift and TMS high goes to exit1. Shift holds on TMS low and goes to exit1 on TMS high. Exit1 goes to update on TMS high and to pause on TMS low. Pause holds on TMS low and goes to exit2 on TMS high. Exit2 goes to update on TMS high and back to shift on TMS low. Update goes to TAP_SEL_DR on TMS high and to TAP_IDLE on TMS low.

Top module: `scan_linker`

## Requirements
- R1: While bp_trst_n is low, the block is held in the following state, without waiting for any clock: the state machine in TAP_RESET, deselected, no ports linked, cpu_gnt low, bp_tdo_en low and loc_oe all zero.
- R2: Five rising TCK edges with TMS high, from any state, reach TAP_RESET. Being in TAP_RESET clears the selection and the link mask.
- R3: The instruction register is 8 bits wide. It captures 8'b0000_0001 in TAP_CAP_IR and shifts right from bp_tdi in TAP_SH_IR, so the LSB leaves first. It is decoded on the rising edge taken in TAP_UPD_IR. Bits [7:6] hold the opcode: 2'b01 is select with address bits [5:0], 2'b10 is link with mask bits [3:0], and any other value does nothing.
- R4: A select command whose address equals slot_id selects the block. Any other address deselects it. Address 6'h3F always deselects.
- R5: bp_tdo_en is high exactly while the block is selected. While bp_tdo_en is low, bp_tdo is 0.
- R6: While the block is selected with a zero mask, its own TDO is presented on the falling TCK edge. Instruction scans pass through the instruction register. Data scans pass through a 1-bit bypass stage that captures 0.
- R7: A link command loads the mask only while the block is selected. A link command received while deselected has no effect.
- R8: While linked, the ports whose mask bit is set are chained in ascending index order from bp_tdi to bp_tdo. Each linked port gets bp_tck and bp_tms and has loc_oe high. Each unlinked port gets TCK 0, TMS 1 and loc_oe low.
- R9: While linked, Update-IR commands are ignored. The link ends only in TAP_RESET.
- R10: cpu_gnt rises on the TCK edge after which cpu_req is high while the block is deselected. It falls on the edge after cpu_req drops. It does not rise while the block is selected.
- R11: While granted, all ports take cpu_tck and cpu_tms, with loc_oe all high. cpu_tdi feeds port 0, each port feeds the next, and port 3 drives cpu_tdo. Select commands are ignored while cpu_req or cpu_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bp_trst_n | input | 1 | Backplane test reset, active low, asynchronous |
| bp_tck | input | 1 | Backplane test clock |
| bp_tms | input | 1 | Backplane mode select |
| bp_tdi | input | 1 | Backplane serial data in |
| bp_tdo | output | 1 | Backplane serial data out |
| bp_tdo_en | output | 1 | Drive enable for bp_tdo (low means high-Z) |
| slot_id | input | 6 | Backplane slot address of this board |
| loc_tck | output | 4 | Clock to each local port |
| loc_tms | output | 4 | Mode select to each local port |
| loc_tdi | output | 4 | Serial data to each local port |
| loc_tdo | input | 4 | Serial data from each local port |
| loc_oe | output | 4 | Drive enable for each local port's outputs |
| cpu_req | input | 1 | On-board master request for the local ports |
| cpu_gnt | output | 1 | Grant of the local ports to the on-board master |
| cpu_tck | input | 1 | On-board master clock |
| cpu_tms | input | 1 | On-board master mode select |
| cpu_tdi | input | 1 | On-board master serial data |
| cpu_tdo | output | 1 | Serial data returned to the on-board master |

## Verification
The assertions take the following for granted:
- bp_trst_n is the only reset.
- slot_id stays constant while out of reset.
- cpu_tck toggles only while cpu_gnt is high.
- The local devices change their TDO only on their own port clock.

The bench keeps to these by changing TMS and TDI 1 ns after each falling TCK edge and sampling TDO 2 ns after that edge. It holds slot_id at 6'h15 throughout. It toggles cpu_tck only after checking the grant. It models each local port as a shift stage of length index plus one, updated on that port's own clock edges.

// File: rtl/slk_pkg.sv
package slk_pkg;

    typedef enum logic [3:0] {
        TAP_RESET,
        TAP_IDLE,
        TAP_SEL_DR,
        TAP_CAP_DR,
        TAP_SH_DR,
        TAP_EX1_DR,
        TAP_PAUSE_DR,
        TAP_EX2_DR,
        TAP_UPD_DR,
        TAP_SEL_IR,
        TAP_CAP_IR,
        TAP_SH_IR,
        TAP_EX1_IR,
        TAP_PAUSE_IR,
        TAP_EX2_IR,
        TAP_UPD_IR
    } tap_state_t;

    localparam int OP_W = 2;
    localparam logic [OP_W-1:0] OP_SELECT = 2'b01;
    localparam logic [OP_W-1:0] OP_LINK   = 2'b10;

endpackage

// File: rtl/slk_tap_fsm.sv
module slk_tap_fsm
    import slk_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr
);

    tap_state_t state_nx;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            TAP_RESET:    state_nx = tms ? TAP_RESET    : TAP_IDLE;
            TAP_IDLE:     state_nx = tms ? TAP_SEL_DR   : TAP_IDLE;
            TAP_SEL_DR:   state_nx = tms ? TAP_SEL_IR   : TAP_CAP_DR;
            TAP_CAP_DR:   state_nx = tms ? TAP_EX1_DR   : TAP_SH_DR;
            TAP_SH_DR:    state_nx = tms ? TAP_EX1_DR   : TAP_SH_DR;
            TAP_EX1_DR:   state_nx = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
            TAP_PAUSE_DR: state_nx = tms ? TAP_EX2_DR   : TAP_PAUSE_DR;
            TAP_EX2_DR:   state_nx = tms ? TAP_UPD_DR   : TAP_SH_DR;
            TAP_UPD_DR:   state_nx = tms ? TAP_SEL_DR   : TAP_IDLE;
            TAP_SEL_IR:   state_nx = tms ? TAP_RESET    : TAP_CAP_IR;
            TAP_CAP_IR:   state_nx = tms ? TAP_EX1_IR   : TAP_SH_IR;
            TAP_SH_IR:    state_nx = tms ? TAP_EX1_IR   : TAP_SH_IR;
            TAP_EX1_IR:   state_nx = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
            TAP_PAUSE_IR: state_nx = tms ? TAP_EX2_IR   : TAP_PAUSE_IR;
            TAP_EX2_IR:   state_nx = tms ? TAP_UPD_IR   : TAP_SH_IR;
            TAP_UPD_IR:   state_nx = tms ? TAP_SEL_DR   : TAP_IDLE;
            default:      state_nx = TAP_RESET;
        endcase
    end

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state <= TAP_RESET;
        end else begin
            state <= state_nx;
        end
    end

    // state decode outputs
    always_comb begin
        in_reset = 1'b0;
        cap_ir   = 1'b0;
        sh_ir    = 1'b0;
        upd_ir   = 1'b0;
        cap_dr   = 1'b0;
        sh_dr    = 1'b0;
        unique case (state)
            TAP_RESET:  in_reset = 1'b1;
            TAP_CAP_IR: cap_ir   = 1'b1;
            TAP_SH_IR:  sh_ir    = 1'b1;
            TAP_UPD_IR: upd_ir   = 1'b1;
            TAP_CAP_DR: cap_dr   = 1'b1;
            TAP_SH_DR:  sh_dr    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/slk_cmd_reg.sv
module slk_cmd_reg
    import slk_pkg::*;
#(
    parameter int IR_W      = 8,
    parameter int ADDR_W    = 6,
    parameter int NUM_PORTS = 4
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 in_reset,
    input  logic                 cap_ir,
    input  logic                 sh_ir,
    input  logic                 upd_ir,
    input  logic                 cap_dr,
    input  logic                 sh_dr,
    input  logic [ADDR_W-1:0]    slot_id,
    input  logic                 cpu_req,
    output logic                 sel_q,
    output logic [NUM_PORTS-1:0] mask_q,
    output logic                 gnt_q,
    output logic                 own_tdo
);

    localparam logic [IR_W-1:0]   IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ADDR_NONE  = {ADDR_W{1'b1}};

    logic [IR_W-1:0]      ir_sh;
    logic                 byp_q;
    logic [OP_W-1:0]      ir_op;
    logic [ADDR_W-1:0]    ir_addr;
    logic [NUM_PORTS-1:0] ir_mask;
    logic                 linked;

    assign ir_op   = ir_sh[IR_W-1 -: OP_W];
    assign ir_addr = ir_sh[ADDR_W-1:0];
    assign ir_mask = ir_sh[NUM_PORTS-1:0];
    assign linked  = |mask_q;

    // instruction and bypass shift paths
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= '0;
            byp_q <= 1'b0;
        end else begin
            if (cap_ir) begin
                ir_sh <= IR_CAPTURE;
            end else if (sh_ir) begin
                ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            end
            if (cap_dr) begin
                byp_q <= 1'b0;
            end else if (sh_dr) begin
                byp_q <= tdi;
            end
        end
    end

    // selection, link mask and on-board master grant
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sel_q  <= 1'b0;
            mask_q <= '0;
            gnt_q  <= 1'b0;
        end else begin
            gnt_q <= cpu_req & (gnt_q | ~sel_q);
            if (in_reset) begin
                sel_q  <= 1'b0;
                mask_q <= '0;
            end else if (upd_ir && !linked) begin
                unique case (ir_op)
                    OP_SELECT: begin
                        if (!gnt_q && !cpu_req) begin
                            sel_q <= (ir_addr == slot_id) && (ir_addr != ADDR_NONE);
                        end
                    end
                    OP_LINK: begin
                        if (sel_q) begin
                            mask_q <= ir_mask;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // own serial output, changed on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            own_tdo <= 1'b0;
        end else if (sh_ir) begin
            own_tdo <= ir_sh[0];
        end else if (sh_dr) begin
            own_tdo <= byp_q;
        end
    end

endmodule

// File: rtl/slk_port_mux.sv
module slk_port_mux #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 bp_tck,
    input  logic                 bp_tms,
    input  logic                 bp_tdi,
    input  logic                 cpu_tck,
    input  logic                 cpu_tms,
    input  logic                 cpu_tdi,
    input  logic                 gnt,
    input  logic [NUM_PORTS-1:0] mask,
    input  logic [NUM_PORTS-1:0] loc_tdo,
    output logic [NUM_PORTS-1:0] loc_tck,
    output logic [NUM_PORTS-1:0] loc_tms,
    output logic [NUM_PORTS-1:0] loc_tdi,
    output logic [NUM_PORTS-1:0] loc_oe,
    output logic                 chain_tdo,
    output logic                 cpu_tdo
);

    // bp_link[i]: serial data entering position i of the backplane chain
    logic [NUM_PORTS:0] bp_link;
    // cpu_link[i]: serial data entering port i of the on-board chain
    logic [NUM_PORTS:0] cpu_link;

    assign bp_link[0]  = bp_tdi;
    assign cpu_link[0] = cpu_tdi;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign bp_link[g+1]  = mask[g] ? loc_tdo[g] : bp_link[g];
        assign cpu_link[g+1] = loc_tdo[g];

        assign loc_tck[g] = gnt ? cpu_tck     : (mask[g] ? bp_tck     : 1'b0);
        assign loc_tms[g] = gnt ? cpu_tms     : (mask[g] ? bp_tms     : 1'b1);
        assign loc_tdi[g] = gnt ? cpu_link[g] : (mask[g] ? bp_link[g] : 1'b0);
        assign loc_oe[g]  = gnt | mask[g];
    end

    assign chain_tdo = bp_link[NUM_PORTS];
    assign cpu_tdo   = cpu_link[NUM_PORTS];

endmodule

// File: rtl/scan_linker.sv
module scan_linker
    import slk_pkg::*;
#(
    parameter int IR_W      = 8,
    parameter int ADDR_W    = 6,
    parameter int NUM_PORTS = 4
) (
    input  logic                 bp_trst_n,
    input  logic                 bp_tck,
    input  logic                 bp_tms,
    input  logic                 bp_tdi,
    output logic                 bp_tdo,
    output logic                 bp_tdo_en,
    input  logic [ADDR_W-1:0]    slot_id,
    output logic [NUM_PORTS-1:0] loc_tck,
    output logic [NUM_PORTS-1:0] loc_tms,
    output logic [NUM_PORTS-1:0] loc_tdi,
    input  logic [NUM_PORTS-1:0] loc_tdo,
    output logic [NUM_PORTS-1:0] loc_oe,
    input  logic                 cpu_req,
    output logic                 cpu_gnt,
    input  logic                 cpu_tck,
    input  logic                 cpu_tms,
    input  logic                 cpu_tdi,
    output logic                 cpu_tdo
);

    tap_state_t           tap_state;
    logic                 in_reset;
    logic                 cap_ir;
    logic                 sh_ir;
    logic                 upd_ir;
    logic                 cap_dr;
    logic                 sh_dr;
    logic                 sel_q;
    logic [NUM_PORTS-1:0] mask_q;
    logic                 gnt_q;
    logic                 own_tdo;
    logic                 chain_tdo;

    slk_tap_fsm u_fsm (
        .tck      (bp_tck),
        .trst_n   (bp_trst_n),
        .tms      (bp_tms),
        .state    (tap_state),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr)
    );

    slk_cmd_reg #(
        .IR_W      (IR_W),
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS)
    ) u_cmd (
        .tck      (bp_tck),
        .trst_n   (bp_trst_n),
        .tdi      (bp_tdi),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .slot_id  (slot_id),
        .cpu_req  (cpu_req),
        .sel_q    (sel_q),
        .mask_q   (mask_q),
        .gnt_q    (gnt_q),
        .own_tdo  (own_tdo)
    );

    slk_port_mux #(
        .NUM_PORTS (NUM_PORTS)
    ) u_mux (
        .bp_tck    (bp_tck),
        .bp_tms    (bp_tms),
        .bp_tdi    (bp_tdi),
        .cpu_tck   (cpu_tck),
        .cpu_tms   (cpu_tms),
        .cpu_tdi   (cpu_tdi),
        .gnt       (gnt_q),
        .mask      (mask_q),
        .loc_tdo   (loc_tdo),
        .loc_tck   (loc_tck),
        .loc_tms   (loc_tms),
        .loc_tdi   (loc_tdi),
        .loc_oe    (loc_oe),
        .chain_tdo (chain_tdo),
        .cpu_tdo   (cpu_tdo)
    );

    assign bp_tdo_en = sel_q;
    assign bp_tdo    = !sel_q ? 1'b0 : ((|mask_q) ? chain_tdo : own_tdo);
    assign cpu_gnt   = gnt_q;

endmodule

// File: rtl/slk_checker.sv
module slk_checker
    import slk_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                 bp_tck,
    input logic                 bp_trst_n,
    input logic                 bp_tdo,
    input logic                 bp_tdo_en,
    input logic                 cpu_req,
    input logic                 cpu_gnt,
    input logic [NUM_PORTS-1:0] loc_tck,
    input logic [NUM_PORTS-1:0] loc_tms,
    input logic [NUM_PORTS-1:0] loc_oe,
    input tap_state_t           tap_state,
    input logic                 sel_q,
    input logic [NUM_PORTS-1:0] mask_q
);

    // R2: TAP_RESET leaves no selection and no link behind
    p_reset_clears_r2: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        (tap_state == TAP_RESET) |=> (!sel_q && mask_q == '0));

    // R5: an undriven backplane output carries 0
    p_tdo_quiet_r5: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        !bp_tdo_en |-> !bp_tdo);

    // R7: a mask exists only under selection
    p_mask_needs_sel_r7: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        (mask_q != '0) |-> sel_q);

    // R9: a live link holds until TAP_RESET
    p_link_hold_r9: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        (mask_q != '0 && tap_state != TAP_RESET) |=> $stable(mask_q));

    // R10: grant only rises after a request seen while deselected
    p_gnt_rise_r10: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        $rose(cpu_gnt) |-> ($past(cpu_req) && !$past(bp_tdo_en)));

    // R11: a granted master owns every port and the backplane output is released
    p_gnt_owns_r11: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        cpu_gnt |-> (!bp_tdo_en && loc_oe == '1));

    // R8: a released port sees a parked clock and TMS high
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_idle
        p_port_idle_r8: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
            !loc_oe[g] |-> (!loc_tck[g] && loc_tms[g]));
    end

endmodule

bind scan_linker slk_checker #(
    .NUM_PORTS (NUM_PORTS)
) u_chk (
    .bp_tck    (bp_tck),
    .bp_trst_n (bp_trst_n),
    .bp_tdo    (bp_tdo),
    .bp_tdo_en (bp_tdo_en),
    .cpu_req   (cpu_req),
    .cpu_gnt   (cpu_gnt),
    .loc_tck   (loc_tck),
    .loc_tms   (loc_tms),
    .loc_oe    (loc_oe),
    .tap_state (tap_state),
    .sel_q     (sel_q),
    .mask_q    (mask_q)
);

// File: tb/test_scan_linker.sv
`timescale 1ns/1ps
module test_scan_linker;

    localparam logic [5:0] MY_SLOT = 6'h15;

    logic       bp_trst_n = 1'b0;
    logic       bp_tck    = 1'b0;
    logic       bp_tms    = 1'b1;
    logic       bp_tdi    = 1'b0;
    logic       bp_tdo;
    logic       bp_tdo_en;
    logic [5:0] slot_id   = MY_SLOT;
    logic [3:0] loc_tck;
    logic [3:0] loc_tms;
    logic [3:0] loc_tdi;
    logic [3:0] loc_tdo;
    logic [3:0] loc_oe;
    logic       cpu_req   = 1'b0;
    logic       cpu_gnt;
    logic       cpu_tck   = 1'b0;
    logic       cpu_tms   = 1'b1;
    logic       cpu_tdi   = 1'b0;
    logic       cpu_tdo;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    logic [1:0] exp_q[$];   // {care, value}
    string      tag_q[$];
    event       ev_s;

    always #4 bp_tck = ~bp_tck;   // 125 MHz

    scan_linker i_scan_linker (
        .bp_trst_n (bp_trst_n),
        .bp_tck    (bp_tck),
        .bp_tms    (bp_tms),
        .bp_tdi    (bp_tdi),
        .bp_tdo    (bp_tdo),
        .bp_tdo_en (bp_tdo_en),
        .slot_id   (slot_id),
        .loc_tck   (loc_tck),
        .loc_tms   (loc_tms),
        .loc_tdi   (loc_tdi),
        .loc_tdo   (loc_tdo),
        .loc_oe    (loc_oe),
        .cpu_req   (cpu_req),
        .cpu_gnt   (cpu_gnt),
        .cpu_tck   (cpu_tck),
        .cpu_tms   (cpu_tms),
        .cpu_tdi   (cpu_tdi),
        .cpu_tdo   (cpu_tdo)
    );

    // local device models: port g is a shift stage of length g+1
    for (genvar g = 0; g < 4; g++) begin : g_dev
        logic [3:0] sh = '0;
        logic       q  = 1'b0;
        always @(posedge loc_tck[g]) sh <= {sh[2:0], loc_tdi[g]};
        always @(negedge loc_tck[g]) q  <= sh[g];
        assign loc_tdo[g] = q;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(ev_s);
            #1;
            if (exp_q.size() != 0) begin
                logic [1:0] it;
                string      tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (it[1]) chk(tg, {31'd0, bp_tdo}, {31'd0, it[0]});
            end
        end
    end

    task automatic tick(input logic tms, input logic tdi);
        @(negedge bp_tck);
        #1;
        bp_tms = tms;
        bp_tdi = tdi;
    endtask

    // scan driver: pushes expected TDO bits, ends in TAP_IDLE with update applied
    task automatic scan(input bit is_ir, input logic [31:0] din, input int n,
                        input int lat, input logic [31:0] pre, input int pre_len,
                        input string req);
        tick(1'b1, 1'b0);
        if (is_ir) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int j = 0; j < n; j++) begin
            @(negedge bp_tck);
            #1;
            if (j >= lat)          exp_q.push_back({1'b1, din[j-lat]});
            else if (j < pre_len)  exp_q.push_back({1'b1, pre[j]});
            else                   exp_q.push_back(2'b00);
            tag_q.push_back(req);
            -> ev_s;
            bp_tdi = din[j];
            bp_tms = (j == n - 1);
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic ir_cmd(input logic [7:0] cmd, input string req);
        scan(1'b1, {24'd0, cmd}, 8, 99, 32'd0, 0, req);
    endtask

    task automatic cpu_cycle();
        cpu_tck = 1'b1; #3;
        cpu_tck = 1'b0; #3;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        #10;
        chk("R1 tdo_en", {31'd0, bp_tdo_en}, 0);
        chk("R1 loc_oe", {28'd0, loc_oe}, 0);
        chk("R1 gnt",    {31'd0, cpu_gnt}, 0);
        chk("R5 tdo low", {31'd0, bp_tdo}, 0);
        @(negedge bp_tck); #1;
        bp_trst_n = 1'b1;
        tick(1'b0, 1'b0);

        // R4: other address leaves block deselected, output released (R5)
        ir_cmd({2'b01, 6'h2A}, "R4");
        chk("R4 other slot", {31'd0, bp_tdo_en}, 0);
        chk("R5 tdo low", {31'd0, bp_tdo}, 0);
        ir_cmd({2'b01, MY_SLOT}, "R4");
        chk("R4 own slot", {31'd0, bp_tdo_en}, 1);

        // R3/R6: own IR capture and pass-through; final IR = NOP
        scan(1'b1, 32'h00B, 12, 8, 32'h01, 8, "R3 ir capture");
        chk("R3 nop keeps sel", {31'd0, bp_tdo_en}, 1);
        // R6: bypass stage
        scan(1'b0, 32'hA5C3, 16, 1, 32'd0, 1, "R6 bypass");

        // R4: 3F deselects; R7: link while deselected ignored
        ir_cmd({2'b01, 6'h3F}, "R4");
        chk("R4 3F deselect", {31'd0, bp_tdo_en}, 0);
        ir_cmd(8'h85, "R7");
        chk("R7 no oe", {28'd0, loc_oe}, 0);
        ir_cmd({2'b01, MY_SLOT}, "R7");
        scan(1'b0, 32'h3C69, 16, 1, 32'd0, 1, "R7 still bypass");

        // R8: link ports 0 and 2
        ir_cmd(8'h85, "R8");
        chk("R8 oe", {28'd0, loc_oe}, 32'h5);
        scan(1'b0, 32'h9E37, 16, 4, 32'd0, 0, "R8 chain 0,2");
        @(posedge bp_tck); #1;
        chk("R8 tck high", {28'd0, loc_tck}, 32'h5);
        chk("R8 tms parked", {31'd0, loc_tms[1]}, 1);

        // R9: IR scan goes through devices; embedded select-3F ignored
        scan(1'b1, 32'h7F5A, 16, 4, 32'd0, 0, "R9 ir through chain");
        chk("R9 still selected", {31'd0, bp_tdo_en}, 1);
        chk("R9 still linked", {28'd0, loc_oe}, 32'h5);

        // R2: five TMS-high clocks
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        chk("R2 deselect", {31'd0, bp_tdo_en}, 0);
        chk("R2 unlink", {28'd0, loc_oe}, 0);

        // R8: all four ports
        ir_cmd({2'b01, MY_SLOT}, "R8");
        ir_cmd(8'h8F, "R8");
        scan(1'b0, 32'h5AC3F1, 24, 10, 32'd0, 0, "R8 chain all");

        // R1: asynchronous reset between edges
        @(negedge bp_tck); #1;
        bp_trst_n = 1'b0;
        #1;
        chk("R1 async en", {31'd0, bp_tdo_en}, 0);
        chk("R1 async oe", {28'd0, loc_oe}, 0);
        @(negedge bp_tck); #1;
        bp_trst_n = 1'b1;
        tick(1'b0, 1'b0);

        // R10: grant while deselected
        @(negedge bp_tck); #1;
        cpu_req = 1'b1;
        chk("R10 not yet", {31'd0, cpu_gnt}, 0);
        @(posedge bp_tck); #1;
        chk("R10 granted", {31'd0, cpu_gnt}, 1);
        chk("R11 oe all", {28'd0, loc_oe}, 32'hF);

        // R11: on-board chain latency 1+2+3+4
        cpu_tdi = 1'b0;
        for (int k = 0; k < 12; k++) cpu_cycle();
        chk("R11 flushed", {31'd0, cpu_tdo}, 0);
        cpu_tdi = 1'b1;
        begin
            int cnt;
            cnt = 0;
            while (cpu_tdo !== 1'b1 && cnt < 20) begin
                cpu_cycle();
                cnt++;
            end
            chk("R11 latency", cnt, 10);
        end

        // R11: select ignored while granted
        ir_cmd({2'b01, MY_SLOT}, "R11");
        chk("R11 select ignored", {31'd0, bp_tdo_en}, 0);

        // R10: release, then request while selected
        @(negedge bp_tck); #1;
        cpu_req = 1'b0;
        @(posedge bp_tck); #1;
        chk("R10 released", {31'd0, cpu_gnt}, 0);
        ir_cmd({2'b01, MY_SLOT}, "R10");
        chk("R10 selected", {31'd0, bp_tdo_en}, 1);
        @(negedge bp_tck); #1;
        cpu_req = 1'b1;
        @(posedge bp_tck); #1;
        @(posedge bp_tck); #1;
        chk("R10 no grant while selected", {31'd0, cpu_gnt}, 0);
        cpu_req = 1'b0;

        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        finish_run();
    end

endmodule